// File: doc/BRIEF.md
# Audio Control Register Receiver (I2C write-only slave)

This block sits beside the analog path of a stereo sound processor and takes its settings from a two-wire I2C controller. It oversamples SCL and SDA on the system clock and finds start and stop conditions. It accepts a transfer only when the first byte carries its own 7-bit module address with a write direction. The second byte selects a target register. The bytes that follow are written into five control registers: left volume, right volume, bass, treble and switch. After each data byte the target moves to the next register in the map.

The switch register is decoded into control outputs for the analog path:
- a mute flag;
- a one-hot stereo-effect select;
- two output-channel source selects;
- an input-pair select.

A register takes a new value only when its data byte has been fully clocked in and acknowledged. A transfer that is broken off by a start condition therefore leaves the settings as they were.

Top module: `audio_ctl_slave`

## Requirements
- R1: After reset, all volume, bass and treble codes are 0 and the switch register is 6'b100000, so mute_o is 1. sda_oe_o and bus_busy_o are 0.
- R2: A falling SDA while SCL is high sets bus_busy_o. A rising SDA while SCL is high clears it.
- R3: The slave acknowledges a first byte only when it equals {MOD_ADDR, 1'b0}. After any other first byte, the slave drives SDA for nothing and changes no register until the next start condition.
- R4: The slave acknowledges the subaddress byte and every data byte by asserting sda_oe_o (SDA pulled low) during the ninth SCL clock.
- R5: Subaddress 0 writes vol_l_o from data bits 5..0. Subaddress 1 writes vol_r_o from bits 5..0. Subaddress 2 writes bass_o from bits 3..0. Subaddress 3 writes treble_o from bits 3..0. Subaddress 8 writes the switch register from bits 5..0. Higher data bits are ignored.
- R6: After each data byte the subaddress advances 0→1→2→3→8. It then stays at 8, so further bytes keep rewriting the switch register.
- R7: A subaddress outside {0,1,2,3,8} is acknowledged, and so are its data bytes, but no register changes.
- R8: A start condition in the middle of a byte aborts the transfer with every register unchanged. The receiver is then ready for a new address byte.
- R9: The switch register is decoded as follows. mute_o is bit 5. src_sel_o is bit 0. effect_o is one-hot at index {bit3, bit4}: bit 0 is forced mono, bit 1 pseudo, bit 2 linear, bit 3 spatial.
- R10: Switch bits 2..1 set the output sources, where 0 selects the left input and 1 selects the right input. 11 gives out_l_sel_o=0 and out_r_sel_o=1 (stereo). 01 gives 0,0 (sound A). 10 gives 1,1 (sound B). 00 is treated as stereo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| bus_busy_o | output | 1 | Bus is between a start and a stop |
| vol_l_o | output | 6 | Left volume code |
| vol_r_o | output | 6 | Right volume code |
| bass_o | output | 4 | Bass code |
| treble_o | output | 4 | Treble code |
| mute_o | output | 1 | Mute active |
| src_sel_o | output | 1 | Input pair select: 0 = pair 1, 1 = pair 2 |
| effect_o | output | 4 | One-hot stereo-effect mode |
| out_l_sel_o | output | 1 | Left output source: 0 = left input, 1 = right input |
| out_r_sel_o | output | 1 | Right output source: 0 = left input, 1 = right input |

## Verification
A wrong receiver state shows up at the ports in two ways: an acknowledge that appears or goes missing on the ninth clock of the same byte, or a control output that takes a value one transfer later. A subaddress sequencer that is off by one moves each byte of a five-byte transfer into the wrong neighbouring field. That error is visible as soon as the stop condition arrives. Switch-decode faults appear directly on the effect and source outputs, so a sweep through all 64 switch codes covers every decode entry.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int VOL_W  = 6;
  localparam int TONE_W = 4;
  localparam int SW_W   = 6;

  localparam logic [7:0] SUB_VOL_L = 8'h00;
  localparam logic [7:0] SUB_VOL_R = 8'h01;
  localparam logic [7:0] SUB_BASS  = 8'h02;
  localparam logic [7:0] SUB_TREB  = 8'h03;
  localparam logic [7:0] SUB_SW    = 8'h08;

  localparam logic [SW_W-1:0] SW_RESET = 6'b100000;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_SUB, RX_DATA, RX_SKIP
  } rx_state_e;

  function automatic logic [7:0] next_sub(input logic [7:0] s);
    case (s)
      SUB_VOL_L: next_sub = SUB_VOL_R;
      SUB_VOL_R: next_sub = SUB_BASS;
      SUB_BASS:  next_sub = SUB_TREB;
      SUB_TREB:  next_sub = SUB_SW;
      default:   next_sub = s;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-1:0], line_i};
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~sync_q[STAGES];
  assign fall_o  = ~sync_q[STAGES-1] & sync_q[STAGES];
endmodule

// File: rtl/i2c_write_rx.sv
module i2c_write_rx
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] MOD_ADDR = 7'h41
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_lvl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  rx_state_e   state_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  shreg_q, sub_q;
  logic        ack_phase_q, wr_pend_q;

  wire start_det = scl_lvl_i & sda_fall_i;
  wire stop_det  = scl_lvl_i & sda_rise_i;
  wire rx_active = (state_q == RX_ADDR) || (state_q == RX_SUB) || (state_q == RX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      sub_q       <= '0;
      ack_phase_q <= 1'b0;
      wr_pend_q   <= 1'b0;
      sda_oe_o    <= 1'b0;
      busy_o      <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q     <= RX_ADDR;
        bit_cnt_q   <= '0;
        ack_phase_q <= 1'b0;
        wr_pend_q   <= 1'b0;
        sda_oe_o    <= 1'b0;
        busy_o      <= 1'b1;
      end else if (stop_det) begin
        state_q     <= RX_IDLE;
        bit_cnt_q   <= '0;
        ack_phase_q <= 1'b0;
        wr_pend_q   <= 1'b0;
        sda_oe_o    <= 1'b0;
        busy_o      <= 1'b0;
      end else if (scl_rise_i && rx_active && !ack_phase_q && bit_cnt_q < 4'd8) begin
        shreg_q   <= {shreg_q[6:0], sda_lvl_i};
        bit_cnt_q <= bit_cnt_q + 4'd1;
      end else if (scl_fall_i) begin
        if (ack_phase_q) begin
          // end of ninth clock: release SDA, commit pending data
          ack_phase_q <= 1'b0;
          sda_oe_o    <= 1'b0;
          bit_cnt_q   <= '0;
          if (wr_pend_q) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= sub_q;
            wr_data_o <= shreg_q;
            sub_q     <= next_sub(sub_q);
            wr_pend_q <= 1'b0;
          end
        end else if (bit_cnt_q == 4'd8 && rx_active) begin
          case (state_q)
            RX_ADDR: begin
              if (shreg_q == {MOD_ADDR, 1'b0}) begin
                state_q     <= RX_SUB;
                ack_phase_q <= 1'b1;
                sda_oe_o    <= 1'b1;
              end else begin
                state_q <= RX_SKIP;
              end
            end
            RX_SUB: begin
              sub_q       <= shreg_q;
              state_q     <= RX_DATA;
              ack_phase_q <= 1'b1;
              sda_oe_o    <= 1'b1;
            end
            default: begin
              wr_pend_q   <= 1'b1;
              ack_phase_q <= 1'b1;
              sda_oe_o    <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R4
  ack_in_transfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> busy_o);
  // R3
  skip_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_SKIP) |-> !sda_oe_o);
  // R6
  sub_from_treble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == SUB_TREB) |-> (sub_q == SUB_SW));
  // R6
  sub_hold_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == SUB_SW) |-> (sub_q == SUB_SW));
  // R8
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_i && sda_fall_i) |=> (state_q == RX_ADDR && !wr_pend_q && !sda_oe_o));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import audio_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic [SW_W-1:0]   sw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_l_o  <= '0;
      vol_r_o  <= '0;
      bass_o   <= '0;
      treble_o <= '0;
      sw_o     <= SW_RESET;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        SUB_VOL_L: vol_l_o  <= wr_data_i[VOL_W-1:0];
        SUB_VOL_R: vol_r_o  <= wr_data_i[VOL_W-1:0];
        SUB_BASS:  bass_o   <= wr_data_i[TONE_W-1:0];
        SUB_TREB:  treble_o <= wr_data_i[TONE_W-1:0];
        SUB_SW:    sw_o     <= wr_data_i[SW_W-1:0];
        default: ;
      endcase
    end
  end

  // R8
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(vol_l_o) && $stable(vol_r_o) && $stable(bass_o)
                  && $stable(treble_o) && $stable(sw_o)));
  // R7
  unmapped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > SUB_TREB && wr_addr_i != SUB_SW) |=>
      ($stable(vol_l_o) && $stable(vol_r_o) && $stable(bass_o)
       && $stable(treble_o) && $stable(sw_o)));
endmodule

// File: rtl/switch_decode.sv
module switch_decode
  import audio_ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW_W-1:0] sw_i,
  output logic            mute_o,
  output logic            src_sel_o,
  output logic [3:0]      effect_o,
  output logic            out_l_sel_o,
  output logic            out_r_sel_o
);
  logic [1:0] eff_idx;
  logic [1:0] ml;

  assign mute_o    = sw_i[5];
  assign src_sel_o = sw_i[0];
  assign eff_idx   = {sw_i[3], sw_i[4]};
  assign ml        = sw_i[2:1];

  for (genvar g = 0; g < 4; g++) begin : g_eff
    assign effect_o[g] = (eff_idx == g[1:0]);
  end

  always_comb begin
    case (ml)
      2'b01:   begin out_l_sel_o = 1'b0; out_r_sel_o = 1'b0; end
      2'b10:   begin out_l_sel_o = 1'b1; out_r_sel_o = 1'b1; end
      default: begin out_l_sel_o = 1'b0; out_r_sel_o = 1'b1; end
    endcase
  end

  // R9
  effect_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(effect_o) == 1);
endmodule

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] MOD_ADDR    = 7'h41,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              bus_busy_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic              mute_o,
  output logic              src_sel_o,
  output logic [3:0]        effect_o,
  output logic              out_l_sel_o,
  output logic              out_r_sel_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [SW_W-1:0] sw;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  i2c_write_rx #(.MOD_ADDR(MOD_ADDR)) rx_i (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .sda_oe_o, .busy_o(bus_busy_o),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  ctl_regfile regs_i (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .vol_l_o, .vol_r_o, .bass_o, .treble_o, .sw_o(sw));

  switch_decode dec_i (
    .clk_i, .rst_ni, .sw_i(sw),
    .mute_o, .src_sel_o, .effect_o, .out_l_sel_o, .out_r_sel_o);
endmodule

// File: tb/audio_ctl_slave_tb_top.sv
module audio_ctl_slave_tb_top;
  localparam logic [6:0] ADDR = 7'h41;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, mute, src, l_sel, r_sel;
  logic [5:0] vl, vr;
  logic [3:0] bs, tr, eff;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  audio_ctl_slave #(.MOD_ADDR(ADDR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .bus_busy_o(busy),
    .vol_l_o(vl), .vol_r_o(vr), .bass_o(bs), .treble_o(tr),
    .mute_o(mute), .src_sel_o(src), .effect_o(eff),
    .out_l_sel_o(l_sel), .out_r_sel_o(r_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = ~sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic chk_regs(input string req, input int el, input int er,
                          input int eb, input int et, input int em);
    chk(vl == el, req, vl, el);
    chk(vr == er, req, vr, er);
    chk(bs == eb, req, bs, eb);
    chk(tr == et, req, tr, et);
    chk(mute == em, req, mute, em);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [5:0] sw;
    logic [1:0] ml;
    int idx;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk_regs("R1", 0, 0, 0, 0, 1);
    chk(sda_oe == 0 && busy == 0, "R1", {sda_oe, busy}, 0);
    rst_n = 1'b1;
    wq(2);

    // R2 busy tracking
    i2c_start();
    chk(busy == 1, "R2", busy, 1);
    i2c_stop();
    chk(busy == 0, "R2", busy, 0);

    // R3 wrong address, then read-direction address
    i2c_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, a); chk(a == 0, "R3", a, 0);
    send_byte(8'h00, a);                chk(a == 0, "R3", a, 0);
    send_byte(8'h15, a);                chk(a == 0, "R3", a, 0);
    i2c_stop();
    i2c_start();
    send_byte({ADDR, 1'b1}, a);         chk(a == 0, "R3", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h15, a);                chk(a == 0, "R3", a, 0);
    i2c_stop();
    chk_regs("R3", 0, 0, 0, 0, 1);

    // R4 R5 R6 R9 R10 sweep through all switch codes with full auto-increment transfers
    for (int i = 0; i < 64; i++) begin
      sw = i[5:0];
      i2c_start();
      send_byte({ADDR, 1'b0}, a); chk(a == 1, "R3", a, 1);
      send_byte(8'h00, a);        chk(a == 1, "R4", a, 1);
      send_byte({2'b11, i[5:0]}, a);        chk(a == 1, "R4", a, 1);
      send_byte({2'b11, 6'(63 - i)}, a);    chk(a == 1, "R4", a, 1);
      send_byte({4'hF, i[3:0]}, a);         chk(a == 1, "R4", a, 1);
      send_byte({4'hF, ~i[3:0]}, a);        chk(a == 1, "R4", a, 1);
      send_byte({2'b11, sw}, a);            chk(a == 1, "R4", a, 1);
      i2c_stop();
      chk_regs("R5_R6", i, 63 - i, i % 16, 15 - (i % 16), sw[5]);
      idx = {sw[3], sw[4]};
      chk(eff == 4'(1 << idx), "R9", eff, 1 << idx);
      chk(src == sw[0], "R9", src, sw[0]);
      ml = sw[2:1];
      case (ml)
        2'b01:   chk(l_sel == 0 && r_sel == 0, "R10", {l_sel, r_sel}, 0);
        2'b10:   chk(l_sel == 1 && r_sel == 1, "R10", {l_sel, r_sel}, 3);
        default: chk(l_sel == 0 && r_sel == 1, "R10", {l_sel, r_sel}, 1);
      endcase
    end
    // now vl=63 vr=0 bs=15 tr=0 sw=63

    // R6 subaddress stays at 8
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h08, a);
    send_byte(8'h2A, a);
    send_byte(8'h05, a); chk(a == 1, "R6", a, 1);
    i2c_stop();
    chk(mute == 0 && src == 1 && eff == 4'b0001, "R6", {mute, src, eff}, 6'b010001);
    chk_regs("R6", 63, 0, 15, 0, 0);

    // R7 unmapped subaddress
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h05, a); chk(a == 1, "R7", a, 1);
    send_byte(8'h00, a); chk(a == 1, "R7", a, 1);
    send_byte(8'h20, a); chk(a == 1, "R7", a, 1);
    i2c_stop();
    chk_regs("R7", 63, 0, 15, 0, 0);
    chk(eff == 4'b0001 && src == 1, "R7", {eff, src}, 5'b00011);

    // R8 start mid-byte aborts, then a repeated-start transfer works
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h00, a);
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    i2c_start();
    send_byte({ADDR, 1'b0}, a); chk(a == 1, "R8", a, 1);
    send_byte(8'h01, a);
    send_byte(8'h11, a);
    i2c_stop();
    chk_regs("R8", 63, 17, 15, 0, 0);

    // R8 abort during the subaddress byte
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    i2c_stop();
    chk_regs("R8", 63, 17, 15, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule